// File: doc/BRIEF.md
# Initial-State Identifier by Distinguishing Experiment

This block runs a black-box experiment on a small five-state Mealy machine that it contains. After a start pulse it applies a fixed five-bit input word to the machine, one bit per clock, and records the five output bits that come back. Each of the five possible starting states answers that word with a different output signature. The block decodes the signature to name the state the machine started in and the state it has reached at the end. A signature that none of the legal states can produce is flagged as an error.

The machine's state can be forced from outside through a preload port. Its states are coded A=0, B=1, C=2, D=3, E=4. Codes 5 to 7 are treated as a broken state, which lets a test plant a fault. Between experiments the machine holds its state, so a second run without a preload starts from where the first one ended.

Top module: `initStateIdent`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done and err are 0, and initState and finalState are 0.
- R2: A start sampled high while idle raises busy in the next cycle. Busy then stays high for exactly five cycles, during which the machine receives the bits 1, 1, 0, 0, 1 in that order.
- R3: done is high for exactly one cycle, the cycle right after the last busy cycle, and busy is low in that cycle.
- R4: The first output bit is taken as the most significant bit of the signature. Signatures 00000, 11001, 00001, 01111 and 10000 report initState 0 (A), 1 (B), 2 (C), 3 (D) and 4 (E).
- R5: finalState reports 1 (B) after starts A or E, and 2 (C) after starts B, C or D.
- R6: A machine in code 5, 6 or 7 outputs 1 and keeps its state on each step. Any signature outside the five in R4 sets err to 1 and reports 7 in both initState and finalState. A legal signature clears err.
- R7: A preload takes effect at a clock edge where busy is low. A preload presented while busy is high has no effect on that run or on the state left for the next run.
- R8: A start presented while busy is high is ignored: the run length and the single done pulse are unchanged.
- R9: Between runs the machine keeps its state, so a run with no preload starts from the final state of the previous run.
- R10: initState, finalState and err change only at the edge that raises done, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an experiment when the block is idle |
| preloadEn | input | 1 | Loads preloadState into the machine under test while idle |
| preloadState | input | 3 | State code to load (A=0 to E=4, 5 to 7 broken) |
| busy | output | 1 | High while the input word is being applied |
| done | output | 1 | One-cycle pulse when the results are updated |
| initState | output | 3 | Decoded starting state, 7 on error |
| finalState | output | 3 | Decoded ending state, 7 on error |
| err | output | 1 | Signature matched no legal starting state |

## Verification
The bench builds the block with its default parameters: a five-bit word, 1 1 0 0 1, and three-bit state codes. With those defaults all five legal starts and all three broken codes can be reached through the preload port. The bench also covers preloads and starts that arrive in the middle of a run, and runs chained back to back, where the final state of one run is the hidden starting state of the next.

// File: rtl/initIdPkg.sv
package initIdPkg;
  localparam int STATE_W = 3;
  localparam int SEQ_LEN = 5;
  localparam logic [SEQ_LEN-1:0] SEQ_WORD = 5'b11001;

  localparam logic [STATE_W-1:0] CODE_A   = 3'd0;
  localparam logic [STATE_W-1:0] CODE_B   = 3'd1;
  localparam logic [STATE_W-1:0] CODE_C   = 3'd2;
  localparam logic [STATE_W-1:0] CODE_D   = 3'd3;
  localparam logic [STATE_W-1:0] CODE_E   = 3'd4;
  localparam logic [STATE_W-1:0] CODE_BAD = 3'd7;

  typedef struct packed {
    logic clear;
    logic step;
    logic last;
  } strobes_t;
endpackage

// File: rtl/mutMachine.sv
module mutMachine
  import initIdPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [STATE_W-1:0] loadState,
  input  logic               step,
  input  logic               stimBit,
  output logic               respBit
);
  logic [STATE_W-1:0] state;
  logic [STATE_W-1:0] nextState;

  always_comb begin
    case (state)
      CODE_A: begin nextState = stimBit ? CODE_C : CODE_B; respBit = 1'b0;    end
      CODE_B: begin nextState = stimBit ? CODE_E : CODE_D; respBit = stimBit; end
      CODE_C: begin nextState = stimBit ? CODE_A : CODE_D; respBit = 1'b0;    end
      CODE_D: begin nextState = stimBit ? CODE_B : CODE_E; respBit = 1'b0;    end
      CODE_E: begin nextState = stimBit ? CODE_C : CODE_E; respBit = 1'b1;    end
      default: begin nextState = state; respBit = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       state <= CODE_A;
    else if (load) state <= loadState;
    else if (step) state <= nextState;
  end

  // R9
  mut_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(state));
endmodule

// File: rtl/initIdCtrl.sv
module initIdCtrl
  import initIdPkg::*;
#(
  parameter int LEN = SEQ_LEN,
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output strobes_t         stb,
  output logic [IDX_W-1:0] bitIdx
);
  typedef enum logic {PH_IDLE, PH_RUN} phase_e;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN - 1);

  phase_e phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      bitIdx <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_RUN;
          bitIdx <= '0;
        end
        PH_RUN: if (bitIdx == LAST_IDX) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase == PH_RUN);
  assign stb.clear = (phase == PH_IDLE) && start;
  assign stb.step  = (phase == PH_RUN);
  assign stb.last  = (phase == PH_RUN) && (bitIdx == LAST_IDX);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R2
  run_len_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !stb.last) |=> busy);
endmodule

// File: rtl/initIdData.sv
module initIdData
  import initIdPkg::*;
#(
  parameter int LEN = SEQ_LEN,
  parameter logic [LEN-1:0] WORD = SEQ_WORD,
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           stb,
  input  logic [IDX_W-1:0]   bitIdx,
  input  logic               busy,
  input  logic               preloadEn,
  input  logic [STATE_W-1:0] preloadState,
  output logic [STATE_W-1:0] initState,
  output logic [STATE_W-1:0] finalState,
  output logic               err
);
  logic           stimBit;
  logic           respBit;
  logic [LEN-2:0] sigReg;
  logic [LEN-1:0] fullSig;
  logic [STATE_W-1:0] decInit;
  logic [STATE_W-1:0] decFinal;
  logic           decErr;

  assign stimBit = WORD[LEN - 1 - int'(bitIdx)];

  mutMachine mut (
    .clk       (clk),
    .rst       (rst),
    .load      (preloadEn && !busy),
    .loadState (preloadState),
    .step      (stb.step),
    .stimBit   (stimBit),
    .respBit   (respBit)
  );

  always_ff @(posedge clk) begin
    if (rst || stb.clear) sigReg <= '0;
    else if (stb.step)    sigReg <= fullSig[LEN-2:0];
  end

  assign fullSig = {sigReg, respBit};

  always_comb begin
    decErr = 1'b0;
    case (fullSig)
      5'b00000: begin decInit = CODE_A; decFinal = CODE_B; end
      5'b11001: begin decInit = CODE_B; decFinal = CODE_C; end
      5'b00001: begin decInit = CODE_C; decFinal = CODE_C; end
      5'b01111: begin decInit = CODE_D; decFinal = CODE_C; end
      5'b10000: begin decInit = CODE_E; decFinal = CODE_B; end
      default:  begin decInit = CODE_BAD; decFinal = CODE_BAD; decErr = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      initState  <= CODE_A;
      finalState <= CODE_A;
      err        <= 1'b0;
    end else if (stb.last) begin
      initState  <= decInit;
      finalState <= decFinal;
      err        <= decErr;
    end
  end

  // R4
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    !err |-> (initState <= CODE_E && finalState <= CODE_E));
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(stb.last) |-> ($stable(initState) && $stable(finalState) && $stable(err)));
endmodule

// File: rtl/initStateIdent.sv
module initStateIdent
  import initIdPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               preloadEn,
  input  logic [STATE_W-1:0] preloadState,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] initState,
  output logic [STATE_W-1:0] finalState,
  output logic               err
);
  localparam int IDX_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;

  strobes_t         stb;
  logic [IDX_W-1:0] bitIdx;

  initIdCtrl #(.LEN(SEQ_LEN)) ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .stb    (stb),
    .bitIdx (bitIdx)
  );

  initIdData #(.LEN(SEQ_LEN), .WORD(SEQ_WORD)) data (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .bitIdx       (bitIdx),
    .busy         (busy),
    .preloadEn    (preloadEn),
    .preloadState (preloadState),
    .initState    (initState),
    .finalState   (finalState),
    .err          (err)
  );
endmodule

// File: tb/initStateIdent_test.sv
`timescale 1ns/1ps
module initStateIdent_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic preloadEn = 1'b0;
  logic [2:0] preloadState = 3'd0;
  logic busy, done, err;
  logic [2:0] initState, finalState;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  initStateIdent uut (
    .clk(clk), .rst(rst), .start(start), .preloadEn(preloadEn),
    .preloadState(preloadState), .busy(busy), .done(done),
    .initState(initState), .finalState(finalState), .err(err)
  );

  // transition table of the machine under test, from the requirements
  function automatic int tNext(int s, int b);
    case (s)
      0: return b ? 2 : 1;
      1: return b ? 4 : 3;
      2: return b ? 0 : 3;
      3: return b ? 1 : 4;
      4: return b ? 2 : 4;
      default: return s;
    endcase
  endfunction
  function automatic int tOut(int s, int b);
    case (s)
      0, 2, 3: return 0;
      1: return b;
      default: return 1;
    endcase
  endfunction

  int stim[5] = '{1, 1, 0, 0, 1};

  // reference model state
  int mState, mIdx, mSig, mInit, mFinal;
  bit mBusy, mDone, mErr;

  task automatic decodeModel(int sig);
    mInit = 7; mFinal = 7; mErr = 1;
    for (int s = 0; s < 5; s++) begin
      int st = s;
      int acc = 0;
      for (int k = 0; k < 5; k++) begin
        acc = (acc << 1) | tOut(st, stim[k]);
        st = tNext(st, stim[k]);
      end
      if (acc == sig) begin mInit = s; mFinal = st; mErr = 0; end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mState = 0; mIdx = 0; mSig = 0; mInit = 0; mFinal = 0;
      mBusy = 0; mDone = 0; mErr = 0;
    end else begin
      mDone = 0;
      if (!mBusy) begin
        if (preloadEn) mState = int'(preloadState);
        if (start) begin mBusy = 1; mIdx = 0; mSig = 0; end
      end else begin
        mSig = (mSig << 1) | tOut(mState, stim[mIdx]);
        mState = tNext(mState, stim[mIdx]);
        if (mIdx == 4) begin
          mBusy = 0; mDone = 1;
          decodeModel(mSig);
        end else mIdx++;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(busy == mBusy, "R2 busy", busy, mBusy);
      check(done == mDone, "R3 done", done, mDone);
      check(int'(initState) == mInit, "R4 initState", initState, mInit);
      check(int'(finalState) == mFinal, "R5 finalState", finalState, mFinal);
      check(err == mErr, "R6 err", err, mErr);
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic waitDone(output int len);
    len = 0;
    do begin @(negedge clk); if (busy) len++; end while (!done && len < 20);
  endtask

  task automatic runExp(bit doPre, int code, int expInit, int expFinal, bit expErr, string req);
    int len;
    @(negedge clk);
    start = 1; preloadEn = doPre; preloadState = 3'(code);
    @(negedge clk);
    start = 0; preloadEn = 0;
    len = 1;
    while (!done && len < 20) begin @(negedge clk); if (busy) len++; end
    check(len == 5, "R2 run length", len, 5);
    check(int'(initState) == expInit, {req, " initState"}, initState, expInit);
    check(int'(finalState) == expFinal, {req, " finalState"}, finalState, expFinal);
    check(err == expErr, {req, " err"}, err, expErr);
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && err == 0, "R1 flags in reset", {busy, done, err}, 0);
    rst = 0;
    @(negedge clk);
    check(initState == 0 && finalState == 0 && busy == 0, "R1 results after reset",
          {initState, finalState}, 0);

    // R4 R5: each legal start
    runExp(1, 0, 0, 1, 0, "R4 start A");
    runExp(1, 1, 1, 2, 0, "R4 start B");
    runExp(1, 2, 2, 2, 0, "R5 start C");
    runExp(1, 3, 3, 2, 0, "R4 start D");
    runExp(1, 4, 4, 1, 0, "R5 start E");

    // R6: broken state codes, then recovery
    runExp(1, 5, 7, 7, 1, "R6 code 5");
    runExp(1, 7, 7, 7, 1, "R6 code 7");
    runExp(1, 6, 7, 7, 1, "R6 code 6");
    runExp(1, 3, 3, 2, 0, "R6 recovery");

    // R9: no preload, start from previous final state (C)
    runExp(0, 0, 2, 2, 0, "R9 chained");

    // R7 R8: preload to E and start while busy must be ignored
    @(negedge clk);
    start = 1; preloadEn = 1; preloadState = 3'd0;
    @(negedge clk);
    start = 0; preloadEn = 0;
    @(negedge clk);
    start = 1; preloadEn = 1; preloadState = 3'd4;
    @(negedge clk);
    start = 0; preloadEn = 0;
    waitDone(len);
    check(int'(initState) == 0, "R7 preload while busy", initState, 0);
    check(int'(finalState) == 1, "R8 start while busy", finalState, 1);
    @(negedge clk);
    check(done == 0 && busy == 0, "R8 no second run", {done, busy}, 0);
    runExp(0, 0, 1, 2, 0, "R7 state left after run");

    // R10: results hold while idle
    repeat (4) @(negedge clk);
    check(initState == 1 && finalState == 2 && err == 0, "R10 hold",
          {initState, finalState}, {3'd1, 3'd2});

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule